// File: doc/BRIEF.md
# Up-Counting Timer Base with Update Events

This block is a 16-bit up-counting timer. A prescaler divides the clock, and the counter climbs once per divided tick. When the counter reaches the auto-reload limit it wraps to zero on the next tick. A repetition down-counter decides which of these wraps raise an update event. On an update event the prescaler ratio, the auto-reload limit and the repetition count are copied from their software-written preload registers into working copies. An update event also sets a sticky flag, which can drive an interrupt/DMA request line.

Software reaches the block through a single-cycle write port. The writable words are a control word, three preload words, an update-generation strobe and a status word that clears the flag. Through the control word software can stop the counter, hold off update events, keep forced updates away from the flag, and choose whether auto-reload writes go through the preload buffer or straight to the working copy.

Top module: `upcount_timer`

## Requirements
- R1: After reset the counter reads 0, and the update pulse, the update flag and the request line are all low.
- R2: While enabled, the counter advances once every (P+1) clock cycles, where P is the working prescaler value. After it reaches the working auto-reload value it returns to 0 on the next tick.
- R3: A wrap that occurs while the repetition counter is zero produces an update event. The update pulse is high for the cycle that follows the wrapping edge, and the flag is set at that same edge.
- R4: With repetition value N loaded, only every (N+1)-th wrap produces an update event.
- R5: New prescaler and auto-reload values written while the auto-reload buffer bit (control bit 3) is set change nothing until the next update event. From that event on, they are in effect.
- R6: When control bit 3 is clear, an auto-reload write also takes effect at once as the wrap limit.
- R7: While hold-update (control bit 1) is set, no update event occurs. Wraps still happen, working copies keep their values, and the flag is not set. After the bit is cleared, the next qualifying wrap produces an update.
- R8: Writing 1 to bit 0 of the generate word (address 4) resets the counter and the prescaler phase to 0. Unless hold-update is set, it also produces an update event, and this works even when the counter is stopped.
- R9: When quiet-force (control bit 2) is set, a generate strobe still produces an update pulse but leaves the flag unchanged. Wrap-driven updates still set the flag.
- R10: The flag stays set until a write to the status word (address 5) with bit 0 equal to 0. A status write with bit 0 equal to 1 has no effect.
- R11: The request line equals the flag gated by the request enable (control bit 4).
- R12: If a generate strobe and a wrap fall on the same cycle, the strobe wins. The counter restarts at 0, and with quiet-force set the flag stays clear.
- R13: While count enable (control bit 0) is low, the counter and the prescaler phase hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 3 | 0 control, 1 prescaler, 2 auto-reload, 3 repetition, 4 generate, 5 status |
| wr_data | input | 16 | Write data |
| cnt_o | output | 16 | Current counter value |
| upd_pulse | output | 1 | One-cycle pulse per update event |
| upd_flag | output | 1 | Sticky update flag |
| irq_req | output | 1 | Interrupt/DMA request |

## Verification
The hardest case to reach is a generate strobe that lands on exactly the cycle in which the counter wraps. Only that case shows whether the strobe takes priority, because with quiet-force set a wrap alone would raise the flag. The bench loads a small auto-reload value with the prescaler at 1:1 and starts the counter from a known restart. It then counts edges so that the strobe write completes on the wrapping edge. A similar edge count places the limit writes and the hold-update toggles mid-period, so that buffered and immediate behaviour give different counter values.

// File: rtl/upcount_timer.sv
module upcount_timer #(
  parameter int CW = 16,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] cnt_o,
  output logic          upd_pulse,
  output logic          upd_flag,
  output logic          irq_req
);
  localparam logic [2:0] A_CTRL = 3'd0, A_PSC = 3'd1, A_ARR = 3'd2,
                         A_REP  = 3'd3, A_GEN = 3'd4, A_STAT = 3'd5;

  logic          run, hold_upd, quiet_ug, arr_buf, irq_en;
  logic [CW-1:0] psc_pre, psc_sh, psc_cnt, arr_pre, arr_sh, cnt;
  logic [RW-1:0] rep_pre, rep_cnt;

  logic wr_ctrl, wr_psc, wr_arr, wr_rep, wr_stat;
  logic ug, tick, wrap, uev, flag_set;

  assign wr_ctrl  = wr_en && wr_addr == A_CTRL;
  assign wr_psc   = wr_en && wr_addr == A_PSC;
  assign wr_arr   = wr_en && wr_addr == A_ARR;
  assign wr_rep   = wr_en && wr_addr == A_REP;
  assign wr_stat  = wr_en && wr_addr == A_STAT;
  assign ug       = wr_en && wr_addr == A_GEN && wr_data[0];

  assign tick     = run && psc_cnt == psc_sh;
  assign wrap     = tick && cnt == arr_sh;
  assign uev      = !hold_upd && (ug || (wrap && rep_cnt == '0));
  assign flag_set = uev && !(ug && quiet_ug);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {irq_en, arr_buf, quiet_ug, hold_upd, run} <= '0;
      psc_pre <= '0;
      arr_pre <= '1;
      rep_pre <= '0;
    end else begin
      if (wr_ctrl) {irq_en, arr_buf, quiet_ug, hold_upd, run} <= wr_data[4:0];
      if (wr_psc)  psc_pre <= wr_data;
      if (wr_arr)  arr_pre <= wr_data;
      if (wr_rep)  rep_pre <= wr_data[RW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc_sh  <= '0;
      arr_sh  <= '1;
      rep_cnt <= '0;
    end else begin
      if (uev) begin
        psc_sh  <= psc_pre;
        arr_sh  <= arr_pre;
        rep_cnt <= rep_pre;
      end else if (wrap && rep_cnt != '0) begin
        rep_cnt <= rep_cnt - 1'b1;
      end
      if (wr_arr && !arr_buf) arr_sh <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      psc_cnt <= '0;
    end else if (ug) begin
      cnt     <= '0;
      psc_cnt <= '0;
    end else if (run) begin
      psc_cnt <= tick ? '0 : psc_cnt + 1'b1;
      if (wrap)      cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_pulse <= 1'b0;
      upd_flag  <= 1'b0;
    end else begin
      upd_pulse <= uev;
      if (flag_set)                  upd_flag <= 1'b1;
      else if (wr_stat && !wr_data[0]) upd_flag <= 1'b0;
    end
  end

  assign cnt_o   = cnt;
  assign irq_req = upd_flag && irq_en;
endmodule

// File: rtl/upcount_timer_chk.sv
module upcount_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt_o,
  input logic          upd_pulse,
  input logic          upd_flag,
  input logic          irq_req,
  input logic          run,
  input logic          hold_upd,
  input logic          ug
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o != $past(cnt_o)) |-> (cnt_o == '0 || cnt_o == CW'($past(cnt_o) + 1'b1))); // R2
  AST_FLAG_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_flag) |-> upd_pulse); // R3
  AST_HOLD_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_upd |=> !upd_pulse); // R7
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> upd_flag); // R11
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ug) |=> $stable(cnt_o)); // R13
endmodule

bind upcount_timer upcount_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_o(cnt_o), .upd_pulse(upd_pulse),
  .upd_flag(upd_flag), .irq_req(irq_req), .run(run),
  .hold_upd(hold_upd), .ug(ug)
);

// File: tb/upcount_timer_tb.sv
module upcount_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] cnt_o;
  logic        upd_pulse, upd_flag, irq_req;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  localparam logic [15:0] EN = 16'h1, HOLD = 16'h2, QUIET = 16'h4, ABUF = 16'h8, IE = 16'h10;

  upcount_timer u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_o(cnt_o), .upd_pulse(upd_pulse), .upd_flag(upd_flag),
    .irq_req(irq_req));

  always #5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(int psc, int arr, int rep, logic [15:0] ctrl);
    wr(3'd0, QUIET);
    wr(3'd1, 16'(psc));
    wr(3'd2, 16'(arr));
    wr(3'd3, 16'(rep));
    wr(3'd4, 16'h1);
    wr(3'd5, 16'h0);
    wr(3'd0, ctrl);
  endtask

  task automatic t_reset;
    chk("R1 cnt", cnt_o, 0);
    chk("R1 pulse", upd_pulse, 0);
    chk("R1 flag", upd_flag, 0);
    chk("R1 irq", irq_req, 0);
  endtask

  task automatic t_basic;
    setup(0, 5, 0, EN);
    step(5); chk("R2 cnt at limit", cnt_o, 5); chk("R3 flag before wrap", upd_flag, 0);
    step(1); chk("R2 wrap to 0", cnt_o, 0); chk("R3 pulse", upd_pulse, 1); chk("R3 flag", upd_flag, 1);
    step(1); chk("R3 pulse one cycle", upd_pulse, 0); chk("R10 flag sticky", upd_flag, 1);
  endtask

  task automatic t_rep;
    setup(0, 2, 2, EN);
    step(3); chk("R4 wrap1 cnt", cnt_o, 0); chk("R4 wrap1 no pulse", upd_pulse, 0);
    step(3); chk("R4 wrap2 no pulse", upd_pulse, 0); chk("R4 flag clear", upd_flag, 0);
    step(3); chk("R4 wrap3 pulse", upd_pulse, 1); chk("R4 wrap3 flag", upd_flag, 1);
    step(9); chk("R4 reload repeat pulse", upd_pulse, 1);
  endtask

  task automatic t_preload;
    setup(0, 5, 0, EN | ABUF);
    wr(3'd1, 16'd1);
    wr(3'd2, 16'd3);
    step(2); chk("R5 old limit and ratio kept", cnt_o, 4);
    step(2); chk("R5 update at old limit", upd_pulse, 1); chk("R5 wrap", cnt_o, 0);
    step(2); chk("R2 ratio 2 first tick", cnt_o, 1);
    step(1); chk("R2 ratio 2 holds", cnt_o, 1);
    step(3); chk("R5 new limit reached", cnt_o, 3);
    step(2); chk("R5 new limit wrap", cnt_o, 0); chk("R5 pulse", upd_pulse, 1);
  endtask

  task automatic t_direct;
    setup(0, 5, 0, EN);
    wr(3'd2, 16'd2);
    step(1); chk("R6 cnt", cnt_o, 2);
    step(1); chk("R6 immediate limit wrap", cnt_o, 0); chk("R6 pulse", upd_pulse, 1);
  endtask

  task automatic t_hold;
    setup(0, 3, 0, EN | HOLD);
    step(4); chk("R7 wrap cnt", cnt_o, 0); chk("R7 no pulse", upd_pulse, 0); chk("R7 no flag", upd_flag, 0);
    wr(3'd1, 16'd1);
    step(3); chk("R7 ratio unchanged", cnt_o, 0); chk("R7 no pulse 2", upd_pulse, 0);
    step(1);
    wr(3'd4, 16'h1);
    chk("R8 strobe resets under hold", cnt_o, 0); chk("R7 strobe no pulse", upd_pulse, 0);
    step(1); chk("R7 ratio still 1", cnt_o, 1);
    wr(3'd0, EN);
    step(1); chk("R7 cnt", cnt_o, 3);
    step(1); chk("R7 resumed pulse", upd_pulse, 1); chk("R7 resumed flag", upd_flag, 1);
    step(2); chk("R7 new ratio after update", cnt_o, 1);
  endtask

  task automatic t_strobe_stopped;
    setup(2, 9, 0, EN);
    step(4); chk("R2 ratio 3", cnt_o, 1);
    wr(3'd0, 16'h0);
    step(3); chk("R13 stopped holds", cnt_o, 1); chk("R13 no pulse", upd_pulse, 0);
    wr(3'd4, 16'h1);
    chk("R8 cnt reset", cnt_o, 0); chk("R8 pulse while stopped", upd_pulse, 1); chk("R8 flag", upd_flag, 1);
    wr(3'd0, EN);
    step(2); chk("R8 prescaler phase reset", cnt_o, 0);
    step(1); chk("R8 first tick", cnt_o, 1);
  endtask

  task automatic t_quiet;
    setup(0, 2, 0, EN | QUIET);
    step(3); chk("R9 wrap pulse", upd_pulse, 1); chk("R9 wrap sets flag", upd_flag, 1);
    wr(3'd5, 16'h0); chk("R10 cleared", upd_flag, 0);
    wr(3'd4, 16'h1);
    chk("R9 strobe pulse", upd_pulse, 1); chk("R9 strobe no flag", upd_flag, 0); chk("R9 cnt", cnt_o, 0);
  endtask

  task automatic t_flag_irq;
    setup(0, 20, 0, EN | IE);
    wr(3'd4, 16'h1);
    chk("R10 strobe flag", upd_flag, 1); chk("R11 irq on", irq_req, 1);
    step(3); chk("R10 still set", upd_flag, 1);
    wr(3'd5, 16'h1); chk("R10 write 1 ignored", upd_flag, 1);
    wr(3'd0, EN); chk("R11 irq gated off", irq_req, 0); chk("R11 flag kept", upd_flag, 1);
    wr(3'd5, 16'h0); chk("R10 write 0 clears", upd_flag, 0);
  endtask

  task automatic t_collide;
    setup(0, 3, 0, EN | QUIET);
    step(3); chk("R12 at limit", cnt_o, 3);
    wr(3'd4, 16'h1);
    chk("R12 cnt 0", cnt_o, 0); chk("R12 pulse", upd_pulse, 1); chk("R12 strobe wins no flag", upd_flag, 0);
    step(1); chk("R12 restart", cnt_o, 1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_basic();
    t_rep();
    t_preload();
    t_direct();
    t_hold();
    t_strobe_stopped();
    t_quiet();
    t_flag_irq();
    t_collide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule